// File: doc/BRIEF.md
# Two-Channel Signed Pulse Counter

The block keeps a signed 16-bit tally driven by two input channels. Each channel has a pulse line and a control line. A rising or falling edge on the pulse line asks for an increment, a decrement or nothing. The level of the same channel's control line then leaves that request as it is, reverses it, or cancels it. When both channels step in the same clock cycle, their contributions are added together.

A per-unit glitch filter can reject pulse or control levels that are shorter than a programmable number of clock cycles. Five watch events are monitored: two thresholds, a high limit, a low limit and a zero crossing. Each event has its own enable. Any enabled event sets sticky flags in a status word and raises one shared interrupt. That interrupt is cleared by writing a one.

Counting can be paused. The tally can be forced to zero either by a configuration bit or by a dedicated external clear input. The block is set up through a small write-only register port.

Top module: `pulse_tally_unit`

## Requirements
- R1: After reset the tally is 0, the status word is 0, and both the raw and the masked interrupt outputs are low.
- R2: Each channel has separate actions for pulse rising and pulse falling edges, encoded 0 = no change, 1 = add one, 2 = subtract one, 3 = no change. The action word holds 8 bits per channel: bits [1:0] rising, bits [3:2] falling, bits [5:4] control-high modifier, bits [7:6] control-low modifier. Channel 1 sits at an offset of 8 bits.
- R3: The modifier selected by the channel's current control level acts on the edge request, encoded 0 = keep, 1 = reverse direction, 2 or 3 = cancel.
- R4: When both channels request a step in the same cycle, the tally moves by their sum.
- R5: With the filter enabled and threshold T, a new level on a pulse or control input is accepted only after it has been held for at least T clock cycles. A shorter level is ignored.
- R6: While the pause bit is set the tally holds its value. While the clear bit or ext_clr_i is high the tally is 0 and no pulse moves it. Clear takes priority over pause.
- R7: A step that reaches or passes the high limit while counting up (or the low limit while counting down), with that event enabled, fires the limit event and sets the tally to 0 on the same step.
- R8: A step whose result equals threshold 0 or threshold 1 fires that threshold event, provided it is enabled.
- R9: The zero-cross event fires on a step that goes from nonzero to zero or that changes sign. Status bits [1:0] record the kind of crossing: 0 = positive to zero, 1 = negative to zero, 2 = negative to positive, 3 = positive to negative. These bits keep their value until the next crossing.
- R10: Status bits [6:2] are sticky event flags in the order threshold 1, threshold 0, low limit, high limit, zero cross. Writing 1 to bit 0 of address 5 clears these flags. The enables sit in mode word bits [20:16] in the same order.
- R11: The raw interrupt is set by any enabled event and cleared by the write described in R10. If an event and the clear write happen in the same cycle, the event wins. irq_o equals the raw interrupt gated by the enable bit. An event that is not enabled sets neither a flag nor the interrupt.
- R12: The register map is as follows. Address 0 holds the action word, event enables and filter enable (bit 21). Address 1 holds the filter threshold in [9:0]. Address 2 holds threshold 0 in [15:0] and threshold 1 in [31:16]. Address 3 holds the high limit in [15:0] and the low limit in [31:16]. Address 4 holds clear [0], pause [1] and interrupt enable [2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 2 | Pulse line of each channel |
| ctrl_i | input | 2 | Control line of each channel |
| ext_clr_i | input | 1 | External clear, holds the tally at zero |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| count_o | output | 16 | Signed tally |
| status_o | output | 7 | Zero-cross kind [1:0] and event flags [6:2] |
| irq_raw_o | output | 1 | Raw interrupt |
| irq_o | output | 1 | Interrupt gated by its enable |

## Verification
Several rules are checked on every cycle by assertions. A clear holds the tally at zero, and a pause freezes it. The tally only moves to a nonzero value when a channel step was present. A high-limit flag appears together with a zero tally. The interrupt only rises together with a flag. A filtered line only changes toward the value its raw input had. The bench scenarios cover what the assertions cannot: the arithmetic of each edge/modifier combination, summing of simultaneous steps, limit and threshold values, the kind of zero crossing, and the filter boundary between T-1 and T cycles.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    EDGE_HOLD = 2'd0, EDGE_INC = 2'd1, EDGE_DEC = 2'd2, EDGE_NOP = 2'd3
  } edge_act_e;

  typedef enum logic [1:0] {
    LVL_KEEP = 2'd0, LVL_FLIP = 2'd1, LVL_STOP = 2'd2, LVL_NOP = 2'd3
  } lvl_act_e;

  typedef struct packed {
    lvl_act_e  on_low;
    lvl_act_e  on_high;
    edge_act_e on_fall;
    edge_act_e on_rise;
  } ch_cfg_t;

  localparam int CH_CFG_W = $bits(ch_cfg_t);

  // event index order is visible in status and enable fields
  localparam int EV_THR1 = 0;
  localparam int EV_THR0 = 1;
  localparam int EV_LOW  = 2;
  localparam int EV_HIGH = 3;
  localparam int EV_ZERO = 4;
  localparam int EV_N    = 5;

  typedef enum logic [1:0] {
    ZC_POS_ZERO = 2'd0, ZC_NEG_ZERO = 2'd1, ZC_NEG_POS = 2'd2, ZC_POS_NEG = 2'd3
  } zc_mode_e;

  localparam logic [2:0] RA_MODE = 3'd0;
  localparam logic [2:0] RA_FILT = 3'd1;
  localparam logic [2:0] RA_THR  = 3'd2;
  localparam logic [2:0] RA_LIM  = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;
  localparam logic [2:0] RA_ICLR = 3'd5;
endpackage

// File: rtl/pt_in_filter.sv
module pt_in_filter #(
  parameter int FLT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [FLT_W-1:0] thr_i,
  input  logic             raw_i,
  output logic             flt_o
);
  logic [FLT_W-1:0] run_q;
  logic [FLT_W:0]   need;
  logic [FLT_W:0]   seen;

  always_comb begin
    need = en_i ? {1'b0, thr_i} : {{FLT_W{1'b0}}, 1'b1};
    seen = {1'b0, run_q} + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_o <= 1'b0;
      run_q <= '0;
    end else if (raw_i == flt_o) begin
      run_q <= '0;
    end else if (seen >= need) begin
      flt_o <= raw_i;
      run_q <= '0;
    end else begin
      run_q <= seen[FLT_W-1:0];
    end
  end

  // R5
  flt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_o) |-> flt_o == $past(raw_i));
endmodule

// File: rtl/pt_chan_step.sv
module pt_chan_step
  import pt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              ctrl_i,
  input  ch_cfg_t           cfg_i,
  output logic signed [1:0] step_o
);
  logic      pulse_q;
  edge_act_e ea;
  lvl_act_e  la;
  logic signed [1:0] req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= pulse_i;
  end

  always_comb begin
    ea = EDGE_HOLD;
    if (pulse_i && !pulse_q)      ea = cfg_i.on_rise;
    else if (!pulse_i && pulse_q) ea = cfg_i.on_fall;
    la = ctrl_i ? cfg_i.on_high : cfg_i.on_low;
    case (ea)
      EDGE_INC: req = 2'sd1;
      EDGE_DEC: req = -2'sd1;
      default:  req = 2'sd0;
    endcase
    case (la)
      LVL_KEEP: step_o = req;
      LVL_FLIP: step_o = -req;
      default:  step_o = 2'sd0;
    endcase
  end
endmodule

// File: rtl/pt_count_core.sv
module pt_count_core
  import pt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic                    clear_i,
  input  logic                    pause_i,
  input  logic [EV_N-1:0]         ev_en_i,
  input  logic signed [CNT_W-1:0] thr0_i,
  input  logic signed [CNT_W-1:0] thr1_i,
  input  logic signed [CNT_W-1:0] hlim_i,
  input  logic signed [CNT_W-1:0] llim_i,
  input  logic                    irq_en_i,
  input  logic                    irq_clr_i,
  output logic signed [CNT_W-1:0] cnt_o,
  output logic [EV_N+1:0]         status_o,
  output logic                    irq_raw_o,
  output logic                    irq_o
);
  logic signed [CNT_W-1:0] cnt_q, cnt_d, cand;
  logic signed [CNT_W:0]   sum;
  logic [EV_N-1:0]         hit, fire, flags_q;
  zc_mode_e                zc_q, zc_kind;
  logic                    live, irq_raw_q;
  logic                    old_pos, old_neg, new_pos, new_neg;

  always_comb begin
    live    = !clear_i && !pause_i && (step_i != '0);
    sum     = $signed({cnt_q[CNT_W-1], cnt_q}) + (CNT_W+1)'(step_i);
    cand    = sum[CNT_W-1:0];
    old_pos = cnt_q > 0;
    old_neg = cnt_q < 0;
    new_pos = cand > 0;
    new_neg = cand < 0;
    hit[EV_THR1] = live && (cand == thr1_i);
    hit[EV_THR0] = live && (cand == thr0_i);
    hit[EV_LOW]  = live && (step_i < 0) && (sum <= (CNT_W+1)'(llim_i));
    hit[EV_HIGH] = live && (step_i > 0) && (sum >= (CNT_W+1)'(hlim_i));
    hit[EV_ZERO] = live && ((old_pos && !new_pos) || (old_neg && !new_neg));
    if (old_pos) zc_kind = new_neg ? ZC_POS_NEG : ZC_POS_ZERO;
    else         zc_kind = new_pos ? ZC_NEG_POS : ZC_NEG_ZERO;
    fire = hit & ev_en_i;
    if (clear_i)                            cnt_d = '0;
    else if (!live)                         cnt_d = cnt_q;
    else if (fire[EV_HIGH] || fire[EV_LOW]) cnt_d = '0;
    else                                    cnt_d = cand;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      flags_q   <= '0;
      zc_q      <= ZC_POS_ZERO;
      irq_raw_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flags_q <= (irq_clr_i ? '0 : flags_q) | fire;
      if (fire[EV_ZERO]) zc_q <= zc_kind;
      if (|fire)          irq_raw_q <= 1'b1;
      else if (irq_clr_i) irq_raw_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign status_o  = {flags_q, zc_q};
  assign irq_raw_o = irq_raw_q;
  assign irq_o     = irq_raw_q & irq_en_i;

  // R6
  clr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  // R6
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && !clear_i) |=> $stable(cnt_q));
  // R2
  step_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_q) && cnt_q != '0) |-> $past(step_i != '0));
  // R7
  lim_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[EV_HIGH]) |-> cnt_q == '0);
  // R11
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_raw_q) |-> flags_q != '0);
endmodule

// File: rtl/pulse_tally_unit.sv
module pulse_tally_unit
  import pt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int FLT_W  = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pulse_i,
  input  logic [NUM_CH-1:0] ctrl_i,
  input  logic              ext_clr_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [EV_N+1:0]   status_o,
  output logic              irq_raw_o,
  output logic              irq_o
);
  localparam int ACT_W  = CH_CFG_W * NUM_CH;
  localparam int EV_LSB = ACT_W;
  localparam int FEN_B  = ACT_W + EV_N;
  localparam int N_IN   = 2 * NUM_CH;
  localparam int STEP_W = $clog2(NUM_CH + 1) + 1;

  logic [ACT_W-1:0]        act_q;
  logic [EV_N-1:0]         ev_en_q;
  logic                    flt_en_q;
  logic [FLT_W-1:0]        flt_thr_q;
  logic signed [CNT_W-1:0] thr0_q, thr1_q, hlim_q, llim_q;
  logic                    clr_q, pause_q, irq_en_q;
  logic                    irq_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      ev_en_q   <= '0;
      flt_en_q  <= 1'b0;
      flt_thr_q <= '0;
      thr0_q    <= '0;
      thr1_q    <= '0;
      hlim_q    <= '0;
      llim_q    <= '0;
      clr_q     <= 1'b0;
      pause_q   <= 1'b0;
      irq_en_q  <= 1'b0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        RA_MODE: begin
          act_q    <= cfg_wdata_i[ACT_W-1:0];
          ev_en_q  <= cfg_wdata_i[EV_LSB +: EV_N];
          flt_en_q <= cfg_wdata_i[FEN_B];
        end
        RA_FILT: flt_thr_q <= cfg_wdata_i[FLT_W-1:0];
        RA_THR: begin
          thr0_q <= cfg_wdata_i[CNT_W-1:0];
          thr1_q <= cfg_wdata_i[CNT_W +: CNT_W];
        end
        RA_LIM: begin
          hlim_q <= cfg_wdata_i[CNT_W-1:0];
          llim_q <= cfg_wdata_i[CNT_W +: CNT_W];
        end
        RA_CTRL: begin
          clr_q    <= cfg_wdata_i[0];
          pause_q  <= cfg_wdata_i[1];
          irq_en_q <= cfg_wdata_i[2];
        end
        default: ;
      endcase
    end
  end

  assign irq_clr = cfg_we_i && (cfg_addr_i == RA_ICLR) && cfg_wdata_i[0];

  // inputs 0..NUM_CH-1 are pulse lines, the rest control lines
  logic [N_IN-1:0] in_raw, in_flt;
  assign in_raw = {ctrl_i, pulse_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_flt
    pt_in_filter #(.FLT_W(FLT_W)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (flt_en_q),
      .thr_i (flt_thr_q),
      .raw_i (in_raw[i]),
      .flt_o (in_flt[i])
    );
  end

  logic signed [1:0] ch_step [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pt_chan_step u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(in_flt[c]),
      .ctrl_i (in_flt[NUM_CH + c]),
      .cfg_i  (ch_cfg_t'(act_q[c*CH_CFG_W +: CH_CFG_W])),
      .step_o (ch_step[c])
    );
  end

  logic signed [STEP_W-1:0] step_sum;
  always_comb begin
    step_sum = '0;
    for (int c = 0; c < NUM_CH; c++) step_sum = step_sum + STEP_W'(ch_step[c]);
  end

  logic signed [CNT_W-1:0] cnt;

  pt_count_core #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_sum),
    .clear_i  (clr_q || ext_clr_i),
    .pause_i  (pause_q),
    .ev_en_i  (ev_en_q),
    .thr0_i   (thr0_q),
    .thr1_i   (thr1_q),
    .hlim_i   (hlim_q),
    .llim_i   (llim_q),
    .irq_en_i (irq_en_q),
    .irq_clr_i(irq_clr),
    .cnt_o    (cnt),
    .status_o (status_o),
    .irq_raw_o(irq_raw_o),
    .irq_o    (irq_o)
  );

  assign count_o = cnt;
endmodule

// File: tb/pulse_tally_unit_test.sv
`timescale 1ns/1ps
module pulse_tally_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  pulse_i = '0;
  logic [1:0]  ctrl_i = '0;
  logic        ext_clr_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [15:0] count_o;
  logic [6:0]  status_o;
  logic        irq_raw_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_tally_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse_i), .ctrl_i(ctrl_i),
    .ext_clr_i(ext_clr_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .count_o(count_o), .status_o(status_o),
    .irq_raw_o(irq_raw_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [15:0]        act;
    logic [1:0]         ctl;
    logic [1:0]         mask;
    logic [3:0]         n;
    logic signed [15:0] exp;
  } vec_t;

  // R2 edge actions, R3 modifiers, R4 simultaneous channels
  localparam vec_t VECS [10] = '{
    '{16'h0001, 2'b00, 2'b01, 4'd5,  16'sd5},  // rise +1
    '{16'h0005, 2'b00, 2'b01, 4'd5,  16'sd10}, // rise and fall +1
    '{16'h0002, 2'b00, 2'b01, 4'd5, -16'sd5},  // rise -1
    '{16'h0011, 2'b01, 2'b01, 4'd5, -16'sd5},  // ctrl high reverses
    '{16'h0011, 2'b00, 2'b01, 4'd5,  16'sd5},  // ctrl low keeps
    '{16'h0081, 2'b00, 2'b01, 4'd5,  16'sd0},  // ctrl low cancels
    '{16'h0101, 2'b00, 2'b11, 4'd5,  16'sd10}, // both +1 same cycle
    '{16'h0201, 2'b00, 2'b11, 4'd5,  16'sd0},  // +1 and -1 cancel
    '{16'h1800, 2'b10, 2'b10, 4'd5,  16'sd5},  // ch1 fall -1 reversed
    '{16'h0003, 2'b00, 2'b01, 4'd5,  16'sd0}   // code 3 no change
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_val();
    return int'($signed(count_o));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulses(input logic [1:0] m, input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      pulse_i = m;
      repeat (hi) @(negedge clk);
      pulse_i = 2'b00;
      repeat (lo) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic xclear();
    ext_clr_i = 1'b1;
    @(negedge clk);
    ext_clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check("R1 count", cnt_val(), 0);
    check("R1 status", int'(status_o), 0);
    check("R1 irq_raw", int'(irq_raw_o), 0);
    check("R1 irq", int'(irq_o), 0);

    for (int v = 0; v < 10; v++) begin
      wr(3'd0, {16'h0, VECS[v].act});
      ctrl_i = VECS[v].ctl;
      xclear();
      if (v == 0) check("R6 ext clear", cnt_val(), 0);
      repeat (3) @(negedge clk);
      pulses(VECS[v].mask, int'(VECS[v].n), 3, 3);
      check($sformatf("R2/R3/R4 vec%0d", v), cnt_val(), int'(VECS[v].exp));
    end
    ctrl_i = 2'b00;

    // R11 event not enabled: no flag, no interrupt
    xclear();
    wr(3'd3, {16'hFF9C, 16'd3});
    wr(3'd4, 32'h4);
    wr(3'd0, 32'h0000_0001);
    pulses(2'b01, 5, 3, 3);
    check("R11 disabled count", cnt_val(), 5);
    check("R11 disabled raw", int'(irq_raw_o), 0);
    check("R10 disabled status", int'(status_o), 0);

    // R7 high limit
    xclear();
    wr(3'd0, 32'h0008_0001);
    pulses(2'b01, 2, 3, 3);
    check("R7 below high", cnt_val(), 2);
    pulses(2'b01, 1, 3, 3);
    check("R7 high reset", cnt_val(), 0);
    check("R10 high flag", int'(status_o), 32'h20);
    check("R11 raw set", int'(irq_raw_o), 1);
    check("R11 irq set", int'(irq_o), 1);
    wr(3'd5, 32'h1);
    check("R11 raw cleared", int'(irq_raw_o), 0);
    check("R10 flags cleared", int'(status_o), 0);

    // R11 masked interrupt
    wr(3'd4, 32'h0);
    pulses(2'b01, 3, 3, 3);
    check("R11 masked raw", int'(irq_raw_o), 1);
    check("R11 masked irq", int'(irq_o), 0);
    wr(3'd5, 32'h1);

    // R7 low limit
    wr(3'd3, {16'hFFFE, 16'd3});
    wr(3'd0, 32'h0004_0002);
    pulses(2'b01, 1, 3, 3);
    check("R7 above low", cnt_val(), -1);
    pulses(2'b01, 1, 3, 3);
    check("R7 low reset", cnt_val(), 0);
    check("R10 low flag", int'(status_o), 32'h10);
    wr(3'd5, 32'h1);

    // R8 thresholds
    xclear();
    wr(3'd2, {16'hFFFD, 16'd4});
    wr(3'd0, 32'h0003_0001);
    pulses(2'b01, 3, 3, 3);
    check("R8 before thr0", int'(status_o), 0);
    pulses(2'b01, 1, 3, 3);
    check("R8 thr0 count", cnt_val(), 4);
    check("R8 thr0 flag", int'(status_o), 32'h08);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h0003_0002);
    pulses(2'b01, 7, 3, 3);
    check("R8 thr1 count", cnt_val(), -3);
    check("R8 thr1 flag", int'(status_o), 32'h04);
    wr(3'd5, 32'h1);

    // R9 zero crossing kinds
    xclear();
    wr(3'd0, 32'h0010_0002);
    pulses(2'b01, 2, 3, 3);
    check("R9 from zero no event", int'(status_o), 0);
    wr(3'd0, 32'h0010_0001);
    pulses(2'b01, 2, 3, 3);
    check("R9 neg to zero", int'(status_o), 32'h41);
    wr(3'd5, 32'h1);
    check("R10 kind kept", int'(status_o), 32'h01);
    pulses(2'b01, 1, 3, 3);
    wr(3'd0, 32'h0010_0002);
    pulses(2'b01, 1, 3, 3);
    check("R9 pos to zero", int'(status_o), 32'h40);
    pulses(2'b01, 1, 3, 3);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h0010_0101);
    pulses(2'b11, 1, 3, 3);
    check("R4 sum step", cnt_val(), 1);
    check("R9 neg to pos", int'(status_o), 32'h42);
    wr(3'd0, 32'h0010_0202);
    pulses(2'b11, 1, 3, 3);
    check("R9 pos to neg", int'(status_o), 32'h43);
    wr(3'd5, 32'h1);

    // R6 pause and clear
    xclear();
    wr(3'd0, 32'h0000_0001);
    pulses(2'b01, 2, 3, 3);
    wr(3'd4, 32'h2);
    pulses(2'b01, 3, 3, 3);
    check("R6 paused", cnt_val(), 2);
    wr(3'd4, 32'h3);
    pulses(2'b01, 2, 3, 3);
    check("R6 clear over pause", cnt_val(), 0);
    wr(3'd4, 32'h0);
    pulses(2'b01, 1, 3, 3);
    check("R6 resumed", cnt_val(), 1);
    ext_clr_i = 1'b1;
    pulses(2'b01, 3, 3, 3);
    check("R6 ext clear held", cnt_val(), 0);
    ext_clr_i = 1'b0;
    @(negedge clk);

    // R5 glitch filter boundary
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h0020_0001);
    repeat (3) @(negedge clk);
    pulses(2'b01, 1, 4, 10);
    check("R5 short ignored", cnt_val(), 0);
    pulses(2'b01, 1, 5, 10);
    check("R5 long accepted", cnt_val(), 1);
    // R12 filter off again via mode word
    wr(3'd0, 32'h0000_0001);
    pulses(2'b01, 1, 2, 3);
    check("R12 filter disabled", cnt_val(), 2);

    finish_run();
  end
endmodule